// File: doc/BRIEF.md
# Two-Wire to Four-Wire Debug Bridge

This block lets a debug probe that has only two wires reach a device with a standard four-wire JTAG test access port. The probe supplies a one-way clock and shares a single data wire with the bridge. The block presents that data wire as three signals: input, output value and output enable. A tri-state pad outside the block joins them into one wire.

The probe clock is never used as a clock. Both probe wires are oversampled in the system clock domain through synchronisers. A high phase of the probe clock in which the data wire toggles is an escape. Six or seven toggles select the bridge, and it then expects a 12-bit activation sequence. Eight or more toggles send it back offline. Once it is active, every JTAG bit is carried in a packet of three probe clock periods. The first period carries TDI inverted, the second carries TMS, and in the third the bridge drives TDO back to the probe. The bridge issues one TCK pulse for each packet.

The probe clock must run at no more than one fifth of the system clock, and its low phase has to last long enough for the bridge to release the data wire after the third slot.

Top module: `twowire_jtag_bridge`

## Requirements
- R1: A synchronous active-high reset puts the bridge in the offline mode with `jtag_tck_o`=0, `jtag_tms_o`=1, `jtag_tdi_o`=0 and `probe_dat_oe_o`=0. Reset given while packets are running also returns the bridge to offline.
- R2: A probe-clock high phase with 6 or 7 data toggles is a selection escape. If the 12 probe-clock high phases that follow carry the activation sequence 12'hC80, sent most significant bit first (activation code 4'hC, extension code 4'h8, check packet 4'h0), the bridge enters packet mode.
- R3: If the 12 bits after a selection escape differ from 12'hC80, the bridge returns to offline and later packets produce no TCK pulse.
- R4: A high phase with 8 or more toggles returns the bridge from packet mode to offline. After that TMS reads 1 and later packets produce no TCK pulse.
- R5: A high phase with 1 to 5 toggles changes nothing. It is not a data bit, it does not move the packet slot, and the mode stays as it was.
- R6: In packet mode the first slot's bit inverted drives TDI and the second slot's bit drives TMS. Both are stable before TCK rises. Each packet gives exactly one TCK pulse, one system clock wide.
- R7: In packet mode `probe_dat_oe_o` rises in the same cycle as TCK. `probe_dat_o` then carries the value of `jtag_tdo_i` taken in that cycle, and the enable falls again after the third slot's falling probe-clock edge. The enable is never high outside packet mode.
- R8: While the bridge is not in packet mode, TCK stays low, the data output enable stays low and TMS stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| probe_clk_i | input | 1 | Probe clock, asynchronous, oversampled |
| probe_dat_i | input | 1 | Shared data wire as seen at the pad |
| probe_dat_o | output | 1 | Value driven onto the shared data wire |
| probe_dat_oe_o | output | 1 | Drive enable for the shared data wire |
| jtag_tck_o | output | 1 | JTAG test clock to the device |
| jtag_tms_o | output | 1 | JTAG mode select to the device |
| jtag_tdi_o | output | 1 | JTAG data to the device |
| jtag_tdo_i | input | 1 | JTAG data from the device |

## Verification
The hardest situations to reach from the ports are an escape that arrives in the middle of a packet and a reset escape while packets are running. In both, the data wire has to toggle inside a single probe-clock high phase while the bridge may itself be driving that wire. The bench models the pad by showing the bridge's own output whenever its enable is high. It then builds high phases with a chosen number of toggles, spaced so that every toggle survives the synchroniser. It places these between the slots of a packet, after an activation, and in place of one. The TCK pulse count, the TMS level and the values caught at the TCK rise show whether the bridge counted the toggles and kept or dropped its mode.

// File: rtl/cjb_pkg.sv
package cjb_pkg;
  typedef enum logic [1:0] {MODE_OFF, MODE_ACT, MODE_ON} mode_t;
  typedef enum logic [1:0] {SLOT_TDI, SLOT_TMS, SLOT_TDO} slot_t;
endpackage

// File: rtl/cjb_sync.sv
module cjb_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) st[0] <= '0;
    else     st[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[i] <= '0;
      else     st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/cjb_escape.sv
// Counts data toggles inside each probe-clock high phase and classifies
// the phase at its falling edge: plain data bit, selection, or reset.
module cjb_escape #(
  parameter int CNT_W   = 4,
  parameter int SEL_MIN = 6,
  parameter int SEL_MAX = 7,
  parameter int RST_MIN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic pclk_s,
  input  logic pdat_s,
  output logic bit_stb,
  output logic bit_val,
  output logic esc_sel,
  output logic esc_rst
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] SEL_LO  = CNT_W'(SEL_MIN);
  localparam logic [CNT_W-1:0] SEL_HI  = CNT_W'(SEL_MAX);
  localparam logic [CNT_W-1:0] RST_LO  = CNT_W'(RST_MIN);

  logic             pclk_d, pdat_d;
  logic [CNT_W-1:0] cnt;
  logic             rise, fall, tog;

  assign rise = pclk_s & ~pclk_d;
  assign fall = ~pclk_s & pclk_d;
  assign tog  = pclk_s & pclk_d & (pdat_s ^ pdat_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      pclk_d  <= 1'b0;
      pdat_d  <= 1'b0;
      cnt     <= '0;
      bit_val <= 1'b0;
      bit_stb <= 1'b0;
      esc_sel <= 1'b0;
      esc_rst <= 1'b0;
    end else begin
      pclk_d  <= pclk_s;
      pdat_d  <= pdat_s;
      if (rise) begin
        cnt     <= '0;
        bit_val <= pdat_s;
      end else if (tog && cnt != CNT_MAX) begin
        cnt <= cnt + 1'b1;
      end
      bit_stb <= fall && (cnt == '0);
      esc_sel <= fall && (cnt >= SEL_LO) && (cnt <= SEL_HI);
      esc_rst <= fall && (cnt >= RST_LO);
    end
  end
endmodule

// File: rtl/cjb_oscan.sv
// Three-slot packet sequencer: TDI slot, TMS slot, TDO return slot.
module cjb_oscan
  import cjb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic online,
  input  logic bit_stb,
  input  logic bit_val,
  input  logic tdo,
  output logic tck,
  output logic tms,
  output logic tdi,
  output logic dat_o,
  output logic dat_oe
);
  slot_t slot;
  logic  go;

  always_ff @(posedge clk) begin
    if (rst || !online) begin
      slot   <= SLOT_TDI;
      go     <= 1'b0;
      tck    <= 1'b0;
      tms    <= 1'b1;
      tdi    <= 1'b0;
      dat_o  <= 1'b0;
      dat_oe <= 1'b0;
    end else begin
      go  <= 1'b0;
      tck <= go;
      if (go) begin
        dat_o  <= tdo;
        dat_oe <= 1'b1;
      end
      if (bit_stb) begin
        case (slot)
          SLOT_TDI: begin
            tdi  <= ~bit_val;
            slot <= SLOT_TMS;
          end
          SLOT_TMS: begin
            tms  <= bit_val;
            go   <= 1'b1;
            slot <= SLOT_TDO;
          end
          default: begin
            dat_oe <= 1'b0;
            slot   <= SLOT_TDI;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/twowire_jtag_bridge.sv
module twowire_jtag_bridge
  import cjb_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter int               ESC_CNT_W   = 4,
  parameter int               CODE_W      = 4,
  parameter logic [CODE_W-1:0] ACT_CODE   = 4'hC,
  parameter logic [CODE_W-1:0] EXT_CODE   = 4'h8,
  parameter logic [CODE_W-1:0] CHK_CODE   = 4'h0
) (
  input  logic clk,
  input  logic rst,
  input  logic probe_clk_i,
  input  logic probe_dat_i,
  output logic probe_dat_o,
  output logic probe_dat_oe_o,
  output logic jtag_tck_o,
  output logic jtag_tms_o,
  output logic jtag_tdi_o,
  input  logic jtag_tdo_i
);
  localparam int               ACT_LEN = 3 * CODE_W;
  localparam int               ACW     = $clog2(ACT_LEN + 1);
  localparam logic [ACT_LEN-1:0] ACT_SEQ = {ACT_CODE, EXT_CODE, CHK_CODE};
  localparam logic [ACW-1:0]   ACT_LAST = ACW'(ACT_LEN - 1);

  logic [1:0]         sync_q;
  logic               bit_stb, bit_val, esc_sel, esc_rst;
  mode_t              mode;
  logic [ACW-1:0]     act_cnt;
  logic [ACT_LEN-1:0] act_sh, act_nxt;

  cjb_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({probe_clk_i, probe_dat_i}),
    .q   (sync_q)
  );

  cjb_escape #(.CNT_W(ESC_CNT_W)) u_esc (
    .clk     (clk),
    .rst     (rst),
    .pclk_s  (sync_q[1]),
    .pdat_s  (sync_q[0]),
    .bit_stb (bit_stb),
    .bit_val (bit_val),
    .esc_sel (esc_sel),
    .esc_rst (esc_rst)
  );

  assign act_nxt = {act_sh[ACT_LEN-2:0], bit_val};

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= MODE_OFF;
      act_cnt <= '0;
      act_sh  <= '0;
    end else if (esc_rst) begin
      mode <= MODE_OFF;
    end else if (esc_sel) begin
      mode    <= MODE_ACT;
      act_cnt <= '0;
      act_sh  <= '0;
    end else if (bit_stb && mode == MODE_ACT) begin
      act_sh  <= act_nxt;
      act_cnt <= act_cnt + 1'b1;
      if (act_cnt == ACT_LAST)
        mode <= (act_nxt == ACT_SEQ) ? MODE_ON : MODE_OFF;
    end
  end

  cjb_oscan u_pkt (
    .clk     (clk),
    .rst     (rst),
    .online  (mode == MODE_ON),
    .bit_stb (bit_stb),
    .bit_val (bit_val),
    .tdo     (jtag_tdo_i),
    .tck     (jtag_tck_o),
    .tms     (jtag_tms_o),
    .tdi     (jtag_tdi_o),
    .dat_o   (probe_dat_o),
    .dat_oe  (probe_dat_oe_o)
  );
endmodule

// File: rtl/cjb_checker.sv
module cjb_checker
  import cjb_pkg::*;
(
  input logic  clk,
  input logic  rst,
  input mode_t mode,
  input logic  esc_rst,
  input logic  tck,
  input logic  tms,
  input logic  tdi,
  input logic  oe
);
  // R8: outside packet mode the JTAG side is parked
  p_offline_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (mode != MODE_ON && $past(mode) != MODE_ON) |-> (!tck && !oe && tms));

  // R6: a TCK pulse lasts one system clock
  p_tck_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    tck |=> !tck);

  // R6: TDI and TMS do not move while TCK is high
  p_tdi_tms_stable_r6: assert property (@(posedge clk) disable iff (rst)
    tck |-> ($stable(tdi) && $stable(tms)));

  // R7: the data enable goes high together with TCK
  p_oe_with_tck_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(tck) |-> $rose(oe));

  // R7: the data enable only starts in packet mode
  p_oe_online_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(oe) |-> (mode == MODE_ON));

  // R4: a reset escape leaves the bridge offline
  p_esc_reset_r4: assert property (@(posedge clk) disable iff (rst)
    esc_rst |=> (mode == MODE_OFF));
endmodule

bind twowire_jtag_bridge cjb_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .mode    (mode),
  .esc_rst (esc_rst),
  .tck     (jtag_tck_o),
  .tms     (jtag_tms_o),
  .tdi     (jtag_tdi_o),
  .oe      (probe_dat_oe_o)
);

// File: tb/tb_twowire_jtag_bridge.sv
module tb_twowire_jtag_bridge;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic probe_clk = 1'b0;
  logic probe_drv = 1'b0;
  logic tdo_drv = 1'b0;
  logic line;
  logic dat_o, dat_oe, tck, tms, tdi;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int   pulses = 0;
  logic tck_prev = 1'b0;
  logic cap_tdi, cap_tms, cap_tdo;
  bit   oe_seen;

  always #10 clk = ~clk;

  assign line = dat_oe ? dat_o : probe_drv;

  twowire_jtag_bridge dut (
    .clk            (clk),
    .rst            (rst),
    .probe_clk_i    (probe_clk),
    .probe_dat_i    (line),
    .probe_dat_o    (dat_o),
    .probe_dat_oe_o (dat_oe),
    .jtag_tck_o     (tck),
    .jtag_tms_o     (tms),
    .jtag_tdi_o     (tdi),
    .jtag_tdo_i     (tdo_drv)
  );

  always @(negedge clk) begin
    if (tck && !tck_prev) begin
      pulses  = pulses + 1;
      cap_tdi = tdi;
      cap_tms = tms;
    end
    tck_prev = tck;
    if (dat_oe) begin
      oe_seen = 1'b1;
      cap_tdo = dat_o;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pbit(input logic b);
    probe_drv = b;
    probe_clk = 1'b0;
    wt(6);
    probe_clk = 1'b1;
    wt(6);
  endtask

  task automatic esc(input int n);
    probe_clk = 1'b0;
    wt(6);
    probe_clk = 1'b1;
    wt(3);
    for (int i = 0; i < n; i++) begin
      probe_drv = ~probe_drv;
      wt(3);
    end
    wt(3);
  endtask

  task automatic settle();
    probe_clk = 1'b0;
    wt(8);
  endtask

  task automatic packet(input logic t_di, input logic t_ms, input logic t_do);
    tdo_drv = t_do;
    oe_seen = 1'b0;
    pbit(~t_di);
    pbit(t_ms);
    pbit(1'b0);
    settle();
  endtask

  task automatic activate(input int n, input logic [11:0] seq);
    esc(n);
    for (int i = 11; i >= 0; i--) pbit(seq[i]);
    settle();
  endtask

  localparam logic [2:0] VEC [8] = '{3'b101, 3'b010, 3'b111, 3'b000,
                                     3'b110, 3'b001, 3'b011, 3'b100};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int p0;
    wt(4);
    // R1: reset state
    chk(tck == 1'b0, "R1 tck", tck, 0);
    chk(tms == 1'b1, "R1 tms", tms, 1);
    chk(tdi == 1'b0, "R1 tdi", tdi, 0);
    chk(dat_oe == 1'b0, "R1 oe", dat_oe, 0);
    rst = 1'b0;
    wt(4);

    // R8: packets before activation do nothing
    p0 = pulses;
    packet(1'b1, 1'b0, 1'b1);
    chk(pulses == p0, "R8 no pulse offline", pulses - p0, 0);
    chk(tms == 1'b1, "R8 tms high offline", tms, 1);
    chk(!oe_seen, "R8 oe low offline", oe_seen, 0);

    // R3: wrong check packet keeps the bridge offline
    activate(6, 12'hC81);
    p0 = pulses;
    packet(1'b0, 1'b0, 1'b0);
    chk(pulses == p0, "R3 wrong sequence no pulse", pulses - p0, 0);

    // R2: correct sequence after a 6-toggle escape
    activate(6, 12'hC80);
    chk(tms == 1'b1 && pulses == p0, "R2 parked after activation", tms, 1);

    // R6 / R7: vector table
    foreach (VEC[k]) begin
      p0 = pulses;
      packet(VEC[k][2], VEC[k][1], VEC[k][0]);
      chk(pulses == p0 + 1, "R6 one pulse per packet", pulses - p0, 1);
      chk(cap_tdi == VEC[k][2], "R6 tdi at tck rise", cap_tdi, VEC[k][2]);
      chk(cap_tms == VEC[k][1], "R6 tms at tck rise", cap_tms, VEC[k][1]);
      chk(oe_seen && cap_tdo == VEC[k][0], "R7 tdo returned", cap_tdo, VEC[k][0]);
      chk(dat_oe == 1'b0, "R7 oe released", dat_oe, 0);
    end

    // R5: a 3-toggle phase inside a packet is skipped
    p0 = pulses;
    tdo_drv = 1'b1;
    oe_seen = 1'b0;
    pbit(1'b0);
    esc(3);
    pbit(1'b0);
    pbit(1'b0);
    settle();
    chk(pulses == p0 + 1, "R5 packet survives short toggles", pulses - p0, 1);
    chk(cap_tdi == 1'b1, "R5 tdi kept", cap_tdi, 1);
    chk(cap_tms == 1'b0, "R5 tms kept", cap_tms, 0);
    chk(cap_tdo == 1'b1, "R5 tdo kept", cap_tdo, 1);

    // R4: reset escape from packet mode
    chk(tms == 1'b0, "R4 tms low before escape", tms, 0);
    esc(8);
    settle();
    chk(tms == 1'b1, "R4 tms high after reset escape", tms, 1);
    p0 = pulses;
    packet(1'b1, 1'b1, 1'b0);
    chk(pulses == p0, "R4 no pulse after reset escape", pulses - p0, 0);

    // R2: 7-toggle escape also selects
    activate(7, 12'hC80);
    p0 = pulses;
    packet(1'b0, 1'b0, 1'b1);
    chk(pulses == p0 + 1, "R2 seven-toggle activation", pulses - p0, 1);
    chk(tms == 1'b0, "R2 tms follows packet", tms, 0);

    // R1: reset while in packet mode
    rst = 1'b1;
    wt(3);
    rst = 1'b0;
    wt(2);
    chk(tms == 1'b1 && dat_oe == 1'b0, "R1 reset from packet mode", tms, 1);
    p0 = pulses;
    packet(1'b1, 1'b0, 1'b0);
    chk(pulses == p0, "R1 offline after reset", pulses - p0, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule